// File: doc/BRIEF.md
# Triggered Image Sensor Timing Emulator

This block stands in for a 12-bit parallel-output image sensor so that a camera front end can be exercised in simulation or in an on-chip loopback. A one-cycle trigger starts a delay of a set number of line periods. When the delay runs out, the block raises a frame-valid signal and plays out a frame. The frame holds a number of line periods. Leading blank lines come first, then the active rows, then trailing blank lines. On each active row, a line-valid signal is high for a fixed number of pixel columns. That window starts a fixed offset into the line, after a sync interval and a porch gap.

The pixel bus carries a deterministic ramp. Its value is the active-row index times the column count plus the column index, truncated to the bus width. A checker can therefore predict every sample. With the free-run input high, the block starts the next frame on its own after a short frame-valid low gap. With the input low, it returns to idle and waits for a new trigger. Every output is registered on the rising clock edge, and a synchronous active-high reset returns the block to idle.

Top module: `trig_sensor_emu`

## Requirements
- R1: Every line period is exactly LINE_CLKS clocks, so consecutive line-valid rising edges within a frame are LINE_CLKS cycles apart.
- R2: On an active row, line-valid rises SYNC_CLKS+PORCH_CLKS cycles after the line starts and stays high for exactly ACT_COLS consecutive cycles.
- R3: Each frame carries exactly ACT_ROWS line-valid pulses.
- R4: Frame-valid spans ROWS_PRE+ACT_ROWS+ROWS_POST line periods. The first line-valid rise comes ROWS_PRE lines after the frame-valid rise. ROWS_POST blank lines follow the last active row. Line-valid is never high while frame-valid is low.
- R5: Frame-valid rises exactly TRIG_LINES*LINE_CLKS cycles after the edge at which a trigger is sampled in idle.
- R6: A trigger sampled during the delay restarts the delay from that edge. This includes the edge at which the delay would otherwise expire.
- R7: A trigger sampled while a frame or the inter-frame gap is in progress has no effect on any output.
- R8: When free-run is high at the last frame edge, frame-valid stays low for GAP_CLKS cycles and the next frame then starts with no trigger. When free-run is low, the block goes idle and frame-valid stays low.
- R9: While line-valid is high, pixel data equals (active row index * ACT_COLS + column index) mod 2^DW. Both indices count from 0.
- R10: Pixel data is 0 in every cycle in which line-valid is low.
- R11: While reset is sampled high, frame-valid, line-valid and pixel data are all 0 after the next clock edge, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Frame trigger, sampled on each rising edge |
| free_run | input | 1 | 1: start the next frame automatically after the gap |
| vact | output | 1 | Frame-valid |
| hact | output | 1 | Line-valid |
| pxd | output | DW | Pixel data, ramp pattern, valid while hact is high |

## Verification
Two pairs of events can land on the same edge. The first pair is a trigger and the expiry of the trigger delay. The second is a trigger and the frame end or inter-frame gap. The bench provokes the first by driving a trigger exactly on the last delay cycle, and it expects the restart to win: frame-valid stays low and rises one full delay after that edge. For the second pair, it fires triggers mid-frame and in the single gap cycle of free-run mode. It judges them by comparing every output on every clock against a behavioural time-offset model. It also measures the frame length and the gap, and both must be unchanged.

// File: rtl/sens_emu_pkg.sv
package sens_emu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FRAME = 2'd2,
    ST_GAP   = 2'd3
  } emu_state_t;
endpackage

// File: rtl/sens_emu_seq.sv
// Frame sequencer: idle / trigger delay / frame / inter-frame gap.
module sens_emu_seq
  import sens_emu_pkg::*;
#(
  parameter int DLY_CLKS = 1536,
  parameter int GAP_CLKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic free_run,
  input  logic frm_last,
  output logic frm_start,
  output logic frm_on
);
  localparam int CMAX = (DLY_CLKS > GAP_CLKS) ? DLY_CLKS : GAP_CLKS;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DLY_CLKS - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CLKS - 1);

  emu_state_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      ST_IDLE: begin
        if (trig) begin
          st_n  = ST_WAIT;
          cnt_n = '0;
        end
      end
      ST_WAIT: begin
        if (trig) begin
          cnt_n = '0;                 // restart wins over expiry
        end else if (cnt == DLY_LAST) begin
          st_n  = ST_FRAME;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_FRAME: begin
        if (frm_last) begin
          st_n  = free_run ? ST_GAP : ST_IDLE;
          cnt_n = '0;
        end
      end
      default: begin                  // ST_GAP
        if (cnt == GAP_LAST) begin
          st_n  = ST_FRAME;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
    endcase
  end

  assign frm_start = (st_n == ST_FRAME) && (st != ST_FRAME);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      frm_on <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      frm_on <= (st_n == ST_FRAME);
    end
  end

  // R6: a trigger during the delay always restarts the count
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && trig) |=> (st == ST_WAIT && cnt == '0));

  // R7: a running frame is not disturbed until its last edge
  a_r7_frame_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FRAME && !frm_last) |=> (st == ST_FRAME));

  // R8: without free-run the frame end leads to idle
  a_r8_stop: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FRAME && frm_last && !free_run) |=> (st == ST_IDLE));
endmodule

// File: rtl/sens_emu_raster.sv
// Line/row counters and line-valid window decode.
module sens_emu_raster #(
  parameter int LINE_CLKS  = 192,
  parameter int ROWS_PRE   = 1,
  parameter int ACT_ROWS   = 18,
  parameter int ROWS_POST  = 1,
  parameter int HACT_START = 28,
  parameter int ACT_COLS   = 66
) (
  input  logic clk,
  input  logic rst,
  input  logic frm_start,
  input  logic frm_on,
  output logic frm_last,
  output logic hact_n,
  output logic hact_q
);
  localparam int LINES = ROWS_PRE + ACT_ROWS + ROWS_POST;
  localparam int PW    = $clog2(LINE_CLKS + 1);
  localparam int LW    = $clog2(LINES + 1);
  localparam logic [PW-1:0] POS_LAST = PW'(LINE_CLKS - 1);
  localparam logic [LW-1:0] LN_LAST  = LW'(LINES - 1);
  localparam logic [PW-1:0] H_BEG    = PW'(HACT_START);
  localparam logic [PW-1:0] H_END    = PW'(HACT_START + ACT_COLS);
  localparam logic [LW-1:0] R_BEG    = LW'(ROWS_PRE);
  localparam logic [LW-1:0] R_END    = LW'(ROWS_PRE + ACT_ROWS);

  logic [PW-1:0] pos, pos_n;
  logic [LW-1:0] line, line_n;
  logic          eol, act_n;

  assign eol      = (pos == POS_LAST);
  assign frm_last = frm_on && eol && (line == LN_LAST);
  assign act_n    = frm_start || (frm_on && !frm_last);

  always_comb begin
    if (frm_start) begin
      pos_n  = '0;
      line_n = '0;
    end else if (frm_on) begin
      pos_n  = eol ? '0 : pos + 1'b1;
      line_n = eol ? ((line == LN_LAST) ? '0 : line + 1'b1) : line;
    end else begin
      pos_n  = pos;
      line_n = line;
    end
  end

  assign hact_n = act_n &&
                  (line_n >= R_BEG) && (line_n < R_END) &&
                  (pos_n >= H_BEG) && (pos_n < H_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      line   <= '0;
      hact_q <= 1'b0;
    end else begin
      pos    <= pos_n;
      line   <= line_n;
      hact_q <= hact_n;
    end
  end

  // R1: line period wraps after exactly LINE_CLKS positions
  a_r1_pos_wrap: assert property (@(posedge clk) disable iff (rst)
    (frm_on && eol && !frm_last) |=> (pos == '0));

  // R3: row counter never leaves the frame range
  a_r3_line_range: assert property (@(posedge clk) disable iff (rst)
    frm_on |-> (line <= LN_LAST));
endmodule

// File: rtl/sens_emu_ramp.sv
// Ramp pixel generator: counts line-valid cycles since frame start.
module sens_emu_ramp #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_start,
  input  logic          hact_n,
  output logic [DW-1:0] pxd
);
  logic [DW-1:0] cnt, base;

  assign base = frm_start ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pxd <= '0;
    end else begin
      cnt <= hact_n ? base + 1'b1 : base;
      pxd <= hact_n ? base : '0;
    end
  end
endmodule

// File: rtl/trig_sensor_emu.sv
module trig_sensor_emu #(
  parameter int DW         = 12,
  parameter int LINE_CLKS  = 192,
  parameter int ACT_COLS   = 66,
  parameter int ACT_ROWS   = 18,
  parameter int ROWS_PRE   = 1,
  parameter int ROWS_POST  = 1,
  parameter int TRIG_LINES = 8,
  parameter int GAP_CLKS   = 1,
  parameter int SYNC_CLKS  = 20,
  parameter int PORCH_CLKS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic          free_run,
  output logic          vact,
  output logic          hact,
  output logic [DW-1:0] pxd
);
  localparam int DLY_CLKS   = TRIG_LINES * LINE_CLKS;
  localparam int HACT_START = SYNC_CLKS + PORCH_CLKS;

  logic frm_start, frm_on, frm_last, hact_n;

  sens_emu_seq #(
    .DLY_CLKS (DLY_CLKS),
    .GAP_CLKS (GAP_CLKS)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .free_run  (free_run),
    .frm_last  (frm_last),
    .frm_start (frm_start),
    .frm_on    (frm_on)
  );

  sens_emu_raster #(
    .LINE_CLKS  (LINE_CLKS),
    .ROWS_PRE   (ROWS_PRE),
    .ACT_ROWS   (ACT_ROWS),
    .ROWS_POST  (ROWS_POST),
    .HACT_START (HACT_START),
    .ACT_COLS   (ACT_COLS)
  ) raster_i (
    .clk       (clk),
    .rst       (rst),
    .frm_start (frm_start),
    .frm_on    (frm_on),
    .frm_last  (frm_last),
    .hact_n    (hact_n),
    .hact_q    (hact)
  );

  sens_emu_ramp #(
    .DW (DW)
  ) ramp_i (
    .clk       (clk),
    .rst       (rst),
    .frm_start (frm_start),
    .hact_n    (hact_n),
    .pxd       (pxd)
  );

  assign vact = frm_on;

  // R4: line-valid only inside frame-valid
  a_r4_hact_in_vact: assert property (@(posedge clk) disable iff (rst)
    hact |-> vact);

  // R9: consecutive pixels in a line step by one
  a_r9_ramp_step: assert property (@(posedge clk) disable iff (rst)
    (hact && $past(hact)) |-> (pxd == $past(pxd) + 1'b1));

  // R10: data bus idles at zero outside line-valid
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !hact |-> (pxd == '0));
endmodule

// File: tb/trig_sensor_emu_tb_top.sv
`timescale 1ns/1ps
module trig_sensor_emu_tb_top;
  localparam int DW  = 12;
  localparam int L   = 192;
  localparam int NC  = 66;
  localparam int NR  = 18;
  localparam int RB  = 1;
  localparam int RA  = 1;
  localparam int TL  = 8;
  localparam int VLO = 1;
  localparam int H0  = 20 + 8;
  localparam int D   = TL * L;
  localparam int FL  = (RB + NR + RA) * L;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic free_run = 1'b0;
  logic vact, hact;
  logic [DW-1:0] pxd;

  always #5 clk = ~clk;

  trig_sensor_emu dut_i (
    .clk(clk), .rst(rst), .trig(trig), .free_run(free_run),
    .vact(vact), .hact(hact), .pxd(pxd)
  );

  int vectors = 0, fails = 0, cyc = 0;
  bit started = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural time-offset model
  int mmode = 0, mt = 0;
  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      mmode = 0; mt = 0;
    end else begin
      case (mmode)
        0: if (trig) begin mmode = 1; mt = 0; end
        1: if (trig) mt = 0;
           else if (mt == D - 1) begin mmode = 2; mt = 0; end
           else mt++;
        2: if (mt == FL - 1) begin mmode = free_run ? 3 : 0; mt = 0; end
           else mt++;
        default: if (mt == VLO - 1) begin mmode = 2; mt = 0; end
                 else mt++;
      endcase
    end
  end

  // per-cycle compare and interval monitor
  bit pv = 0, ph = 0;
  int rise_c = 0, fall_c = 0, hrise_c = 0, hfall_c = 0, nlines = 0;
  bit fall_seen = 0, fr_at_fall = 0;
  always @(negedge clk) begin
    if (started && !finished) begin
      int l, p, ep;
      bit ev, eh;
      ev = (mmode == 2);
      l = mt / L; p = mt % L;
      eh = ev && l >= RB && l < RB + NR && p >= H0 && p < H0 + NC;
      ep = eh ? (((l - RB) * NC + (p - H0)) % (1 << DW)) : 0;
      chk(vact === ev, "R5 R6 R7 R8 vact", int'(vact), int'(ev));
      chk(hact === eh, "R1 R2 R3 R4 hact", int'(hact), int'(eh));
      chk(pxd === DW'(ep), "R9 R10 pxd", int'(pxd), ep);
      if (rst) begin
        pv = 0; ph = 0; nlines = 0; fall_seen = 0;
      end else begin
        if (vact && !pv) begin
          if (fall_seen && fr_at_fall) chk(cyc - fall_c == VLO, "R8 gap", cyc - fall_c, VLO);
          rise_c = cyc; nlines = 0;
        end
        if (hact && !ph) begin
          nlines++;
          if (nlines == 1) chk(cyc - rise_c == RB * L + H0, "R4 first line", cyc - rise_c, RB * L + H0);
          else chk(cyc - hrise_c == L, "R1 line period", cyc - hrise_c, L);
          hrise_c = cyc;
        end
        if (!hact && ph) begin
          chk(cyc - hrise_c == NC, "R2 line width", cyc - hrise_c, NC);
          hfall_c = cyc;
        end
        if (!vact && pv) begin
          chk(nlines == NR, "R3 rows", nlines, NR);
          chk(cyc - hfall_c == (RA + 1) * L - H0 - NC, "R4 tail", cyc - hfall_c, (RA + 1) * L - H0 - NC);
          fall_c = cyc; fall_seen = 1; fr_at_fall = free_run;
        end
        pv = vact; ph = hact;
      end
    end
  end

  // caller is at a negedge; returns the edge at which trig was sampled
  task automatic pulse_trig(output int t);
    trig = 1'b1;
    @(negedge clk);
    t = cyc;
    trig = 1'b0;
  endtask

  task automatic wait_rise(output int t);
    do @(negedge clk); while (!vact);
    t = cyc;
  endtask

  task automatic wait_fall(output int t);
    do @(negedge clk); while (vact);
    t = cyc;
  endtask

  task automatic summary;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual=hung expected=complete");
    summary();
  end

  initial begin
    int t0, t1, r, f, r2;
    repeat (4) @(negedge clk);
    chk(!vact && !hact && pxd == 0, "R11 reset state", int'(pxd), 0);
    rst = 1'b0;
    @(negedge clk);

    // single triggered frame, trigger mid-frame ignored
    pulse_trig(t0);
    wait_rise(r);
    chk(r - t0 == D, "R5 trigger delay", r - t0, D);
    repeat (1000) @(negedge clk);
    pulse_trig(t1);
    wait_fall(f);
    chk(f - r == FL, "R7 frame length", f - r, FL);
    repeat (300) @(negedge clk);
    chk(vact == 0, "R7 no extra frame", int'(vact), 0);

    // retrigger inside the delay
    pulse_trig(t0);
    repeat (700) @(negedge clk);
    pulse_trig(t1);
    wait_rise(r);
    chk(r - t1 == D, "R6 restart", r - t1, D);
    wait_fall(f);
    @(negedge clk);

    // retrigger on the very edge the delay would expire
    pulse_trig(t0);
    while (cyc < t0 + D - 1) @(negedge clk);
    pulse_trig(t1);
    chk(t1 == t0 + D, "R6 collision edge", t1, t0 + D);
    wait_rise(r);
    chk(r - t1 == D, "R6 restart on expiry", r - t1, D);
    wait_fall(f);
    @(negedge clk);

    // free-running frames, trigger in the gap cycle
    free_run = 1'b1;
    pulse_trig(t0);
    wait_rise(r);
    wait_fall(f);
    pulse_trig(t1);
    chk(vact == 1, "R8 auto restart", int'(vact), 1);
    r2 = cyc;
    chk(r2 - f == VLO, "R8 gap length", r2 - f, VLO);
    repeat (100) @(negedge clk);
    free_run = 1'b0;
    wait_fall(f);
    chk(f - r2 == FL, "R7 gap trigger ignored", f - r2, FL);
    repeat (300) @(negedge clk);
    chk(vact == 0, "R8 stop to idle", int'(vact), 0);

    // reset in the middle of a frame
    pulse_trig(t0);
    wait_rise(r);
    repeat (500) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!vact && !hact && pxd == 0, "R11 mid-frame reset", int'(vact), 0);
    rst = 1'b0;
    @(negedge clk);
    pulse_trig(t0);
    wait_rise(r);
    chk(r - t0 == D, "R5 delay after reset", r - t0, D);
    wait_fall(f);
    repeat (10) @(negedge clk);
    summary();
  end
endmodule